// File: doc/BRIEF.md
# Single-Cycle Bypass Mesh Router

This block is one router of a two-dimensional mesh network-on-chip. It has five ports: local, north, south, east and west. Each port has a valid/ready flit channel in each direction. Every flit carries its own permission to skip routers. This is a small hop budget, stored next to the destination coordinates and the payload. Because of it, no setup message and no sideband wires are needed ahead of the traffic. The request is examined only by the routers the flit actually passes through.

A flit may go straight through this router in the same cycle, with no register on the way. It arrives on a cardinal input, keeps moving in the same direction, and still has budget left. The opposite output must also be free and ready. Such a flit leaves with its budget reduced by one. Any other flit is held in a one-entry buffer at its input. It is routed X first, then Y, and it competes round-robin for its output on the following cycles. A flit that leaves from a buffer on a cardinal output starts with a fresh budget. A flit delivered to the local port has its budget cleared.

Top module: `flit_bypass_router`

## Requirements
- R1: After reset, every `out_valid_o` bit is 0 and every `in_ready_o` bit is 1.
- R2: Port index 0 is local, 1 is north (y+1), 2 is south (y-1), 3 is east (x+1) and 4 is west (x-1). A flit is `{dst_x, dst_y, hops, payload}`, with the most significant field first. A buffered flit is routed as follows: east if dst_x > X_ID, west if dst_x < X_ID, otherwise north if dst_y > Y_ID, south if dst_y < Y_ID, else local. It is offered at the earliest one cycle after it is accepted. On a cardinal output its hops field is set to MAX_HOPS.
- R3: Every flit on the local output has hops = 0. Its other fields are unchanged.
- R4: A flit can go straight through in the same cycle if all of these hold: it arrives on a cardinal input, its hops is non-zero, and its XY route is the port opposite its input. That output must also have no buffered contender, and its ready must be high. The flit then appears on that output in the same cycle, with hops reduced by 1 and all other fields unchanged.
- R5: A flit arriving with hops = 0 is always buffered.
- R6: A flit whose route turns, or which ends at this router, is always buffered.
- R7: A buffered flit requesting an output wins that output over a flit trying to go straight through. The incoming flit is buffered instead.
- R8: If the straight-through output's ready is low, the incoming flit is buffered. Nothing is driven on that output in that cycle.
- R9: A flit entering on the local input is never passed straight through.
- R10: Buffered flits contending for one output are served round-robin in rising input index from a pointer that starts at 0. The pointer moves past the winner only when the output's ready is high.
- R11: `in_ready_o` is low when that input's buffer is full and its flit cannot go straight through. A buffered flit keeps its output valid until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 5 | Flit offered on each input |
| in_ready_o | output | 5 | Input accepts the flit this cycle |
| in_flit_i | input | 5 x FLIT_W | Incoming flits |
| out_valid_o | output | 5 | Flit driven on each output |
| out_ready_i | input | 5 | Downstream accepts the output flit |
| out_flit_o | output | 5 x FLIT_W | Outgoing flits |

## Verification
A flit can try to go straight through in the same cycle that a buffered flit is waiting for the same output. The straight-through path and the arbitration path then collide. The bench provokes this in two steps. First, it parks a local flit for the east output while east ready is held low. Second, it offers a budgeted westside flit heading east. The bench then checks three things: the buffered flit owns the output, the incoming flit is accepted into its buffer, and after release the round-robin order serves them local first. Constrained random single-flit trials cover every input, budget and destination. Each trial predicts from the rules above whether the flit goes straight through or is buffered.

// File: rtl/flit_router_pkg.sv
package flit_router_pkg;
  localparam int unsigned NUM_PORTS = 5;
  localparam int unsigned P_LOCAL   = 0;
  localparam int unsigned P_NORTH   = 1;
  localparam int unsigned P_SOUTH   = 2;
  localparam int unsigned P_EAST    = 3;
  localparam int unsigned P_WEST    = 4;

  // port on the far side of the router from port p (local maps to itself)
  function automatic int unsigned straight_out(int unsigned p);
    case (p)
      P_NORTH: return P_SOUTH;
      P_SOUTH: return P_NORTH;
      P_EAST:  return P_WEST;
      P_WEST:  return P_EAST;
      default: return P_LOCAL;
    endcase
  endfunction
endpackage

// File: rtl/xy_route.sv
module xy_route
  import flit_router_pkg::*;
#(
  parameter int unsigned COORD_W = 3,
  parameter int unsigned X_ID    = 2,
  parameter int unsigned Y_ID    = 2
) (
  input  logic [COORD_W-1:0]   dst_x_i,
  input  logic [COORD_W-1:0]   dst_y_i,
  output logic [NUM_PORTS-1:0] dir_o
);
  localparam logic [COORD_W-1:0] XC = COORD_W'(X_ID);
  localparam logic [COORD_W-1:0] YC = COORD_W'(Y_ID);

  always_comb begin
    dir_o = '0;
    if (dst_x_i > XC)      dir_o[P_EAST]  = 1'b1;
    else if (dst_x_i < XC) dir_o[P_WEST]  = 1'b1;
    else if (dst_y_i > YC) dir_o[P_NORTH] = 1'b1;
    else if (dst_y_i < YC) dir_o[P_SOUTH] = 1'b1;
    else                   dir_o[P_LOCAL] = 1'b1;
  end
endmodule

// File: rtl/flit_in_buf.sv
module flit_in_buf #(
  parameter int unsigned FLIT_W = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [FLIT_W-1:0] flit_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [FLIT_W-1:0] flit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      flit_o  <= '0;
    end else if (push_i) begin
      valid_o <= 1'b1;
      flit_o  <= flit_i;
    end else if (pop_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_NO_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !pop_i) |-> !push_i); // R11
  AST_BUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !pop_i) |=> (valid_o && $stable(flit_o))); // R11
endmodule

// File: rtl/rr_arb.sv
module rr_arb #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] win;
  logic          found;

  always_comb begin
    gnt_o = '0;
    win   = ptr_q;
    found = 1'b0;
    for (int off = 0; off < int'(N); off++) begin
      if (!found && req_i[(int'(ptr_q) + off) % int'(N)]) begin
        found = 1'b1;
        win   = IW'((int'(ptr_q) + off) % int'(N));
        gnt_o[(int'(ptr_q) + off) % int'(N)] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ptr_q <= '0;
    else if (adv_i && found) ptr_q <= (win == LAST) ? '0 : win + 1'b1;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R10
  AST_GNT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0); // R10
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_q)); // R10
endmodule

// File: rtl/flit_bypass_router.sv
module flit_bypass_router
  import flit_router_pkg::*;
#(
  parameter int unsigned COORD_W  = 3,
  parameter int unsigned HOP_W    = 3,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned X_ID     = 2,
  parameter int unsigned Y_ID     = 2,
  parameter int unsigned MAX_HOPS = 3,
  localparam int unsigned NP      = NUM_PORTS,
  localparam int unsigned FLIT_W  = 2 * COORD_W + HOP_W + DATA_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NP-1:0]              in_valid_i,
  output logic [NP-1:0]              in_ready_o,
  input  logic [NP-1:0][FLIT_W-1:0]  in_flit_i,
  output logic [NP-1:0]              out_valid_o,
  input  logic [NP-1:0]              out_ready_i,
  output logic [NP-1:0][FLIT_W-1:0]  out_flit_o
);
  localparam int unsigned HOP_LSB = DATA_W;
  localparam int unsigned DY_LSB  = HOP_LSB + HOP_W;
  localparam int unsigned DX_LSB  = DY_LSB + COORD_W;

  logic [NP-1:0][NP-1:0]     in_dir;   // [input][output]
  logic [NP-1:0][NP-1:0]     buf_dir;  // [input][output]
  logic [NP-1:0][NP-1:0]     gnt_all;  // [output][input]
  logic [NP-1:0][FLIT_W-1:0] buf_flit;
  logic [NP-1:0]             buf_valid, push, pop;
  logic [NP-1:0]             byp_cand, byp_go, out_busy;

  for (genvar p = 0; p < NP; p++) begin : g_in
    localparam int unsigned SP = straight_out(p);

    xy_route #(.COORD_W(COORD_W), .X_ID(X_ID), .Y_ID(Y_ID)) u_rt_in (
      .dst_x_i (in_flit_i[p][DX_LSB +: COORD_W]),
      .dst_y_i (in_flit_i[p][DY_LSB +: COORD_W]),
      .dir_o   (in_dir[p])
    );

    flit_in_buf #(.FLIT_W(FLIT_W)) u_buf (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[p]),
      .flit_i  (in_flit_i[p]),
      .pop_i   (pop[p]),
      .valid_o (buf_valid[p]),
      .flit_o  (buf_flit[p])
    );

    xy_route #(.COORD_W(COORD_W), .X_ID(X_ID), .Y_ID(Y_ID)) u_rt_buf (
      .dst_x_i (buf_flit[p][DX_LSB +: COORD_W]),
      .dst_y_i (buf_flit[p][DY_LSB +: COORD_W]),
      .dir_o   (buf_dir[p])
    );

    if (p == P_LOCAL) begin : g_loc
      assign byp_cand[p] = 1'b0;  // injection always lands in the buffer
    end else begin : g_card
      assign byp_cand[p] = in_valid_i[p] && (in_flit_i[p][HOP_LSB +: HOP_W] != '0)
                           && in_dir[p][SP];
    end

    assign byp_go[p]     = byp_cand[p] && !out_busy[SP] && out_ready_i[SP];
    assign in_ready_o[p] = byp_go[p] || !buf_valid[p];
    assign push[p]       = in_valid_i[p] && !byp_go[p] && !buf_valid[p];

    if (p != P_LOCAL) begin : g_chk
      AST_TURN_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i[p] && in_ready_o[p] && !in_dir[p][SP]) |=> buf_valid[p]); // R6
      AST_ZERO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i[p] && in_ready_o[p] && in_flit_i[p][HOP_LSB +: HOP_W] == '0)
        |=> buf_valid[p]); // R5
      AST_BYP_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byp_go[p] |-> (out_valid_o[SP] && out_flit_o[SP][HOP_LSB +: HOP_W]
                       == in_flit_i[p][HOP_LSB +: HOP_W] - 1'b1)); // R4
    end else begin : g_chk_loc
      AST_LOCAL_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i[p] && in_ready_o[p]) |=> buf_valid[p]); // R9
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    localparam int unsigned SI = straight_out(o);
    localparam logic [HOP_W-1:0] LAUNCH = (o == P_LOCAL) ? '0 : HOP_W'(MAX_HOPS);

    logic [NP-1:0]     req;
    logic [FLIT_W-1:0] sel, fwd;

    always_comb begin
      for (int p = 0; p < int'(NP); p++) req[p] = buf_valid[p] && buf_dir[p][o];
    end

    assign out_busy[o] = |req;

    rr_arb #(.N(NP)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req),
      .adv_i  (out_ready_i[o] && out_busy[o]),
      .gnt_o  (gnt_all[o])
    );

    always_comb begin
      sel = '0;
      for (int p = 0; p < int'(NP); p++) if (gnt_all[o][p]) sel = buf_flit[p];
      sel[HOP_LSB +: HOP_W] = LAUNCH;
      fwd = in_flit_i[SI];
      fwd[HOP_LSB +: HOP_W] = in_flit_i[SI][HOP_LSB +: HOP_W] - 1'b1;
    end

    if (o == P_LOCAL) begin : g_loc
      assign out_valid_o[o] = out_busy[o];
      assign out_flit_o[o]  = out_busy[o] ? sel : '0;
      AST_LOCAL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o[o] |-> (out_flit_o[o][HOP_LSB +: HOP_W] == '0)); // R3
    end else begin : g_card
      assign out_valid_o[o] = out_busy[o] || byp_go[SI];
      assign out_flit_o[o]  = out_busy[o] ? sel : (byp_go[SI] ? fwd : '0);
      AST_BUF_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_busy[o] |-> !byp_go[SI]); // R7
    end

    AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_busy[o] && !out_ready_i[o]) |=> out_valid_o[o]); // R11
  end

  always_comb begin
    pop = '0;
    for (int o = 0; o < int'(NP); o++)
      for (int p = 0; p < int'(NP); p++)
        if (gnt_all[o][p] && out_ready_i[o]) pop[p] = 1'b1;
  end

  AST_POP_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop & ~buf_valid) == '0); // R2
endmodule

// File: tb/flit_bypass_router_tb.sv
module flit_bypass_router_tb;
  localparam int NP = 5;
  localparam int FW = 25;
  localparam int XI = 2, YI = 2, MH = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     in_valid = '0, in_ready, out_valid, out_ready = '1;
  logic [NP-1:0][FW-1:0] in_flit = '0, out_flit;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flit_bypass_router u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_flit_i(in_flit),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_flit_o(out_flit)
  );

  function automatic logic [FW-1:0] mk(int dx, int dy, int h, int d);
    return {3'(dx), 3'(dy), 3'(h), 16'(d)};
  endfunction

  function automatic int route(int dx, int dy);
    if (dx > XI) return 3;
    if (dx < XI) return 4;
    if (dy > YI) return 1;
    if (dy < YI) return 2;
    return 0;
  endfunction

  function automatic int straight(int p);
    case (p) 1: return 2; 2: return 1; 3: return 4; 4: return 3; default: return 0; endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rand_trial();
    int p  = $urandom_range(0, 4);
    int dx = $urandom_range(0, 4);
    int dy = $urandom_range(0, 4);
    int h  = $urandom_range(0, 7);
    int d  = $urandom_range(0, 65535);
    int rp = route(dx, dy);
    int sp = straight(p);
    bit byp = (p != 0) && (h != 0) && (rp == sp);
    string why;
    if (byp)          why = "R4";
    else if (p == 0)  why = "R9";
    else if (h == 0)  why = "R5";
    else              why = "R6";
    @(negedge clk);
    in_valid[p] = 1'b1;
    in_flit[p]  = mk(dx, dy, h, d);
    #2;
    chk(in_ready[p] == 1'b1, why, 32'(in_ready), 32'h1f);
    if (byp) begin
      chk(out_valid == 5'(1 << sp), "R4", 32'(out_valid), 32'(1 << sp));
      chk(out_flit[sp] == mk(dx, dy, h - 1, d), "R4", out_flit[sp], mk(dx, dy, h - 1, d));
      @(negedge clk);
      in_valid[p] = 1'b0;
      #2;
      chk(out_valid == '0, "R4", 32'(out_valid), 0);
    end else begin
      chk(out_valid == '0, why, 32'(out_valid), 0);
      @(negedge clk);
      in_valid[p] = 1'b0;
      #2;
      chk(out_valid == 5'(1 << rp), "R2", 32'(out_valid), 32'(1 << rp));
      if (rp == 0)
        chk(out_flit[0] == mk(dx, dy, 0, d), "R3", out_flit[0], mk(dx, dy, 0, d));
      else
        chk(out_flit[rp] == mk(dx, dy, MH, d), "R2", out_flit[rp], mk(dx, dy, MH, d));
      @(negedge clk);
      #2;
      chk(out_valid == '0, "R2", 32'(out_valid), 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    #20 rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(out_valid == '0, "R1", 32'(out_valid), 0);
    chk(in_ready == '1, "R1", 32'(in_ready), 32'h1f);

    // collision: parked local flit vs straight-through west flit, both for east
    @(negedge clk);
    out_ready[3] = 1'b0;
    in_valid[0] = 1'b1; in_flit[0] = mk(4, 0, 0, 16'haaaa);
    #2;
    chk(in_ready[0] == 1'b1, "R9", 32'(in_ready), 32'h1f);
    @(negedge clk);
    in_valid[0] = 1'b0;
    in_valid[4] = 1'b1; in_flit[4] = mk(4, 2, 2, 16'hbbbb);
    #2;
    chk(out_valid[3] == 1'b1 && out_flit[3] == mk(4, 0, MH, 16'haaaa), "R7",
        out_flit[3], mk(4, 0, MH, 16'haaaa));
    chk(in_ready[4] == 1'b1, "R7", 32'(in_ready), 32'h1f);
    @(negedge clk);
    in_flit[4] = mk(4, 2, 2, 16'hcccc);
    #2;
    chk(in_ready[4] == 1'b0, "R11", 32'(in_ready[4]), 0);
    chk(out_valid[3] == 1'b1 && out_flit[3] == mk(4, 0, MH, 16'haaaa), "R11",
        out_flit[3], mk(4, 0, MH, 16'haaaa));
    @(negedge clk);
    in_valid[4] = 1'b0;
    out_ready[3] = 1'b1;
    #2;
    chk(out_flit[3] == mk(4, 0, MH, 16'haaaa), "R10", out_flit[3], mk(4, 0, MH, 16'haaaa));
    @(negedge clk);
    #2;
    chk(out_valid[3] == 1'b1 && out_flit[3] == mk(4, 2, MH, 16'hbbbb), "R10",
        out_flit[3], mk(4, 2, MH, 16'hbbbb));
    @(negedge clk);
    #2;
    chk(out_valid == '0, "R10", 32'(out_valid), 0);

    // downstream stalled: straight-through refused, flit buffered
    @(negedge clk);
    out_ready[3] = 1'b0;
    in_valid[4] = 1'b1; in_flit[4] = mk(3, 1, 1, 16'hdddd);
    #2;
    chk(out_valid[3] == 1'b0, "R8", 32'(out_valid), 0);
    chk(in_ready[4] == 1'b1, "R8", 32'(in_ready), 32'h1f);
    @(negedge clk);
    in_valid[4] = 1'b0;
    out_ready[3] = 1'b1;
    #2;
    chk(out_valid[3] == 1'b1 && out_flit[3] == mk(3, 1, MH, 16'hdddd), "R8",
        out_flit[3], mk(3, 1, MH, 16'hdddd));
    @(negedge clk);
    #2;
    chk(out_valid == '0, "R8", 32'(out_valid), 0);

    for (int i = 0; i < 400; i++) rand_trial();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule